// File: doc/BRIEF.md
# Parallel flash command and reset controller

This block is the control state machine of a parallel NOR-style flash device. It watches the bus write strobes (active-low chip enable and write enable, with address and data), decodes the multi-cycle command sequences, and selects the operating mode. The modes are read array, identification readout, program, sector or whole-device erase with suspend and resume, and a fast-program mode that needs only two bus writes per program. The block drives a ready/busy flag, an output-enable for the data pins, a select between the array and the identification register, and the mask of sectors being erased. Program and erase are modelled as busy periods of configurable length in clock cycles.

A separate reset sequencer serves the hardware reset pin. While the pin is low, the bus is shut off and the command machine is forced back to read array. How long the internal reset lasts depends on whether the device was busy when the pin fell. After the pin rises, a further recovery delay must pass before the bus is accepted again.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write is taken once per low period of `ce_ni`&`we_ni`, on its first cycle. The unlock pair is 0xAA to low address 0x555, then 0x55 to 0x2AA. A third write of 0xA0 to 0x555 arms programming. The next write starts a program: `rdy_o` goes low for exactly PROG_LEN cycles, and the device then returns to read array.
- R2: A third write of 0x20 to 0x555 enters bypass mode. In bypass, 0xA0 followed by any write starts a program of PROG_LEN cycles, after which the device stays in bypass. The pair 0x90 then 0x00 leaves bypass for read array. In bypass, every other write is ignored.
- R3: A wrong address or data value in any unlock or setup cycle discards the sequence and keeps the mode held before it (read array or identification). A write of 0xF0 in such a cycle, or while idle outside bypass, selects read array.
- R4: A third write of 0x90 to 0x555 selects identification mode, in which `id_sel_o` is 1 while not busy. A later 0xF0 clears it.
- R5: Erase setup is unlock, 0x80 to 0x555, unlock. Then 0x30 to any address adds sector addr[AW-1 -: SECT_BITS] to `erase_mask_o` and restarts a window of EWIN_LEN cycles. More 0x30 writes within the window add sectors. Any other write aborts the erase and clears the mask. When the window expires, `rdy_o` is low for ERASE_LEN cycles, and the mask then clears.
- R6: In place of the 0x30 writes, 0x10 to 0x555 selects every sector and starts the erase at once.
- R7: Writes during a program or erase are ignored. The one exception is 0xB0 during an erase, which suspends it: `rdy_o` goes high, the mask and the remaining count are held, and only 0x30 resumes the erase.
- R8: While `hw_rst_ni` is low, `dout_en_o` is 0, writes are ignored, and the command machine returns to read array.
- R9: If `hw_rst_ni` falls while `rdy_o` is 0, `rdy_o` stays 0 for RST_LONG cycles from the fall. If it falls while `rdy_o` is 1, `rdy_o` stays 1.
- R10: The bus (reads and writes) is blocked until the reset timer (RST_LONG or RST_SHORT from the fall) has expired and RECOV_LEN+1 cycles have passed since the first high sample of `hw_rst_ni`.
- R11: With `ce_ni` high, `dout_en_o` is 0 whatever `oe_ni` is. An operation in progress runs to completion while the chip is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low logic reset |
| hw_rst_ni | input | 1 | Device hardware reset pin, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Bus address |
| data_i | input | 8 | Bus write data (low byte) |
| rdy_o | output | 1 | Ready (1) / busy (0) |
| dout_en_o | output | 1 | Data pins driven |
| id_sel_o | output | 1 | Reads return the identification register |
| erase_mask_o | output | 2**SECT_BITS | Sectors selected for erase |

## Verification
The bench goes after the reset sequencer's two timings. A design that chose the wrong length would release `rdy_o` early after a reset that hit a program, or drop `rdy_o` after a reset that came while idle. It also checks that the data pins stay dark for one cycle too many rather than one too few on release. Command-path corners covered: a mistyped second unlock cycle made from identification mode must leave identification selected, not drop to read array. Leaving bypass must really stop two-cycle programming. An erase suspend must freeze the count so that the erase, once resumed, finishes at exactly the remaining length. Writes that land during busy, during reset or in the recovery gap must leave every output untouched.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PGM_ADDR, ST_PROG,
    ST_ESETUP, ST_EU1, ST_EU2, ST_EWIN, ST_ERASE, ST_ESUSP, ST_BYP90
  } st_e;

  typedef enum logic [1:0] {MD_READ, MD_IDENT, MD_BYPASS} md_e;

  localparam logic [10:0] ADR_A     = 11'h555;
  localparam logic [10:0] ADR_B     = 11'h2AA;
  localparam logic [7:0]  CMD_UNLK1 = 8'hAA;
  localparam logic [7:0]  CMD_UNLK2 = 8'h55;
  localparam logic [7:0]  CMD_PGM   = 8'hA0;
  localparam logic [7:0]  CMD_ESET  = 8'h80;
  localparam logic [7:0]  CMD_IDENT = 8'h90;
  localparam logic [7:0]  CMD_BYP   = 8'h20;
  localparam logic [7:0]  CMD_RESET = 8'hF0;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_SUSP  = 8'hB0;
  localparam logic [7:0]  CMD_BEXIT = 8'h00;
endpackage

// File: rtl/flash_wr_det.sv
module flash_wr_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic allow_i,
  output logic stb_o
);
  logic wr_now, wr_q;
  assign wr_now = !ce_ni && !we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_now;
  end

  // first cycle of a write low period only
  assign stb_o = wr_now && !wr_q && allow_i;
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
  parameter int RST_LONG  = 10,
  parameter int RST_SHORT = 4,
  parameter int RECOV_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic busy_i,
  output logic hold_o,
  output logic rdy_low_o,
  output logic bus_ok_o
);
  localparam int MAXR = (RST_LONG > RST_SHORT) ? RST_LONG : RST_SHORT;
  localparam int CW   = $clog2(MAXR + 1);
  localparam int RW   = $clog2(RECOV_LEN + 2);

  logic          pin_q, long_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b1;
      long_q <= 1'b0;
      cnt_q  <= '0;
      rec_q  <= '0;
    end else begin
      pin_q <= pin_ni;
      if (!pin_ni && pin_q) begin
        cnt_q  <= busy_i ? CW'(RST_LONG) : CW'(RST_SHORT);
        long_q <= busy_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (pin_ni && !pin_q)   rec_q <= RW'(RECOV_LEN);
      else if (rec_q != '0)   rec_q <= rec_q - 1'b1;
    end
  end

  assign hold_o    = !pin_ni;
  assign rdy_low_o = long_q && (cnt_q != '0);
  assign bus_ok_o  = pin_ni && pin_q && (cnt_q == '0) && (rec_q == '0);

  // R9
  long_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_ni && pin_q && busy_i) |=> rdy_low_o);
  // R9
  short_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_ni && pin_q && !busy_i) |=> !rdy_low_o);

  if (RECOV_LEN > 0) begin : g_rec_chk
    // R10
    rise_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_ni && !pin_q) |=> !bus_ok_o);
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_ctrl_pkg::*;
#(
  parameter int AW        = 12,
  parameter int SB        = 2,
  parameter int PROG_LEN  = 6,
  parameter int ERASE_LEN = 20,
  parameter int EWIN_LEN  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic            stb_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      data_i,
  output logic            busy_o,
  output logic            id_sel_o,
  output logic [(1<<SB)-1:0] mask_o
);
  localparam int NS   = 1 << SB;
  localparam int MAXB = (PROG_LEN > ERASE_LEN) ? PROG_LEN : ERASE_LEN;
  localparam int CW   = $clog2(MAXB + 1);
  localparam int WW   = $clog2(EWIN_LEN + 1);

  st_e           st_q;
  md_e           md_q;
  logic [CW-1:0] cnt_q;
  logic [WW-1:0] wcnt_q;
  logic [NS-1:0] mask_q, sec_bit;
  logic          at_a, at_b, is_f0;

  assign at_a    = addr_i[10:0] == ADR_A;
  assign at_b    = addr_i[10:0] == ADR_B;
  assign is_f0   = data_i == CMD_RESET;
  assign sec_bit = NS'(1) << addr_i[AW-1 -: SB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; md_q <= MD_READ;
      cnt_q <= '0; wcnt_q <= '0; mask_q <= '0;
    end else if (hold_i) begin
      st_q <= ST_IDLE; md_q <= MD_READ;
      cnt_q <= '0; wcnt_q <= '0; mask_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (stb_i) begin
          if (md_q == MD_BYPASS) begin
            if (data_i == CMD_PGM)        st_q <= ST_PGM_ADDR;
            else if (data_i == CMD_IDENT) st_q <= ST_BYP90;
          end else if (is_f0)            md_q <= MD_READ;
          else if (data_i == CMD_UNLK1 && at_a) st_q <= ST_U1;
        end
        ST_U1, ST_EU1: if (stb_i) begin
          if (data_i == CMD_UNLK2 && at_b) st_q <= (st_q == ST_U1) ? ST_U2 : ST_EU2;
          else begin st_q <= ST_IDLE; if (is_f0) md_q <= MD_READ; end
        end
        ST_U2: if (stb_i) begin
          st_q <= ST_IDLE;
          if (at_a && data_i == CMD_PGM)        st_q <= ST_PGM_ADDR;
          else if (at_a && data_i == CMD_ESET)  st_q <= ST_ESETUP;
          else if (at_a && data_i == CMD_IDENT) md_q <= MD_IDENT;
          else if (at_a && data_i == CMD_BYP)   md_q <= MD_BYPASS;
          else if (is_f0)                       md_q <= MD_READ;
        end
        ST_PGM_ADDR: if (stb_i) begin
          st_q  <= ST_PROG;
          cnt_q <= CW'(PROG_LEN);
        end
        ST_PROG: begin
          if (cnt_q == CW'(1)) begin
            st_q <= ST_IDLE;
            if (md_q != MD_BYPASS) md_q <= MD_READ;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_ESETUP: if (stb_i) begin
          if (data_i == CMD_UNLK1 && at_a) st_q <= ST_EU1;
          else begin st_q <= ST_IDLE; if (is_f0) md_q <= MD_READ; end
        end
        ST_EU2: if (stb_i) begin
          st_q <= ST_IDLE;
          if (at_a && data_i == CMD_CHIP) begin
            st_q <= ST_ERASE; cnt_q <= CW'(ERASE_LEN); mask_q <= '1;
          end else if (data_i == CMD_SECT) begin
            st_q <= ST_EWIN; mask_q <= sec_bit; wcnt_q <= WW'(EWIN_LEN);
          end else if (is_f0) md_q <= MD_READ;
        end
        ST_EWIN: begin
          if (stb_i) begin
            if (data_i == CMD_SECT) begin
              mask_q <= mask_q | sec_bit; wcnt_q <= WW'(EWIN_LEN);
            end else begin
              st_q <= ST_IDLE; mask_q <= '0;
              if (is_f0) md_q <= MD_READ;
            end
          end else if (wcnt_q == WW'(1)) begin
            st_q <= ST_ERASE; cnt_q <= CW'(ERASE_LEN);
          end else wcnt_q <= wcnt_q - 1'b1;
        end
        ST_ERASE: begin
          if (stb_i && data_i == CMD_SUSP) st_q <= ST_ESUSP;
          else if (cnt_q == CW'(1)) begin
            st_q <= ST_IDLE; md_q <= MD_READ; mask_q <= '0;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_ESUSP: if (stb_i && data_i == CMD_SECT) st_q <= ST_ERASE;
        ST_BYP90: if (stb_i) begin
          st_q <= ST_IDLE;
          if (data_i == CMD_BEXIT) md_q <= MD_READ;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q == ST_PROG) || (st_q == ST_ERASE);
  assign id_sel_o = (md_q == MD_IDENT) && !busy_o && (st_q != ST_ESUSP);
  assign mask_o   = mask_q;

  // R1
  prog_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG && cnt_q > CW'(1) && !hold_i) |=>
      (st_q == ST_PROG && cnt_q == $past(cnt_q) - 1'b1));
  // R7
  susp_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ESUSP && !hold_i) |=> ($stable(cnt_q) && $stable(mask_q)));
  // R6
  chip_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EU2 && stb_i && !hold_i && at_a && data_i == CMD_CHIP) |=> (&mask_q));
  // R5
  first_sector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EU2 && stb_i && !hold_i && data_i == CMD_SECT) |=> ($countones(mask_q) == 1));
  // R8
  hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (st_q == ST_IDLE && md_q == MD_READ && mask_q == '0));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW        = 12,
  parameter int SECT_BITS = 2,
  parameter int PROG_LEN  = 6,
  parameter int ERASE_LEN = 20,
  parameter int EWIN_LEN  = 5,
  parameter int RST_LONG  = 10,
  parameter int RST_SHORT = 4,
  parameter int RECOV_LEN = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      hw_rst_ni,
  input  logic                      ce_ni,
  input  logic                      we_ni,
  input  logic                      oe_ni,
  input  logic [AW-1:0]             addr_i,
  input  logic [7:0]                data_i,
  output logic                      rdy_o,
  output logic                      dout_en_o,
  output logic                      id_sel_o,
  output logic [(1<<SECT_BITS)-1:0] erase_mask_o
);
  logic hold, rdy_low, bus_ok, stb, busy;

  flash_rst_seq #(
    .RST_LONG(RST_LONG), .RST_SHORT(RST_SHORT), .RECOV_LEN(RECOV_LEN)
  ) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_ni(hw_rst_ni), .busy_i(!rdy_o),
    .hold_o(hold), .rdy_low_o(rdy_low), .bus_ok_o(bus_ok)
  );

  flash_wr_det u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni),
    .allow_i(bus_ok), .stb_o(stb)
  );

  flash_cmd_fsm #(
    .AW(AW), .SB(SECT_BITS), .PROG_LEN(PROG_LEN),
    .ERASE_LEN(ERASE_LEN), .EWIN_LEN(EWIN_LEN)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .stb_i(stb),
    .addr_i(addr_i), .data_i(data_i), .busy_o(busy),
    .id_sel_o(id_sel_o), .mask_o(erase_mask_o)
  );

  assign rdy_o     = !(busy || rdy_low);
  assign dout_en_o = bus_ok && !ce_ni && !oe_ni;

  // R8
  rst_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_rst_ni |-> !dout_en_o);
  // R11
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !dout_en_o);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
  localparam int AW = 12, SB = 2, NS = 4;
  localparam int PL = 6, EL = 20, WL = 5, RL = 10, RS = 4, RC = 3;
  // model states
  localparam int IDLE = 0, U1 = 1, U2 = 2, PADR = 3, PROG = 4, ESET = 5, EU1 = 6,
                 EU2 = 7, EWIN = 8, ERASE = 9, ESUSP = 10, B90 = 11;
  localparam int RD = 0, ID = 1, BY = 2;

  logic clk_i = 0, rst_ni = 0, hw_rst_ni = 1, ce_ni = 1, we_ni = 1, oe_ni = 1;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic rdy_o, dout_en_o, id_sel_o;
  logic [NS-1:0] erase_mask_o;

  int vecs = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  flash_cmd_ctrl #(.AW(AW), .SECT_BITS(SB), .PROG_LEN(PL), .ERASE_LEN(EL), .EWIN_LEN(WL),
    .RST_LONG(RL), .RST_SHORT(RS), .RECOV_LEN(RC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_rst_ni(hw_rst_ni), .ce_ni(ce_ni), .we_ni(we_ni),
    .oe_ni(oe_ni), .addr_i(addr_i), .data_i(data_i), .rdy_o(rdy_o),
    .dout_en_o(dout_en_o), .id_sel_o(id_sel_o), .erase_mask_o(erase_mask_o));

  always #4 clk_i = ~clk_i;

  int m_st, m_md, m_cnt, m_wcnt, m_rcnt, m_rec;
  bit m_rlong, m_pinq, m_wrq;
  logic [NS-1:0] m_mask;

  function automatic bit m_rdy();
    return !(m_st == PROG || m_st == ERASE) && !(m_rlong && m_rcnt != 0);
  endfunction
  function automatic bit m_ok();
    return hw_rst_ni && m_pinq && m_rcnt == 0 && m_rec == 0;
  endfunction

  always @(posedge clk_i) begin : model
    bit rdy, ok, stb, f0, aa, bb;
    int d;
    logic [NS-1:0] sbit;
    if (!rst_ni) begin
      m_st = IDLE; m_md = RD; m_cnt = 0; m_wcnt = 0; m_rcnt = 0; m_rec = 0;
      m_rlong = 0; m_pinq = 1; m_wrq = 0; m_mask = '0;
    end else begin
      rdy = m_rdy(); ok = m_ok();
      stb = !ce_ni && !we_ni && !m_wrq && ok;
      d = data_i; f0 = (d == 'hF0);
      aa = (addr_i[10:0] == 11'h555); bb = (addr_i[10:0] == 11'h2AA);
      sbit = '0; sbit[addr_i[AW-1:AW-SB]] = 1'b1;
      if (!hw_rst_ni && m_pinq) begin m_rcnt = rdy ? RS : RL; m_rlong = !rdy; end
      else if (m_rcnt > 0) m_rcnt--;
      if (hw_rst_ni && !m_pinq) m_rec = RC;
      else if (m_rec > 0) m_rec--;
      m_pinq = hw_rst_ni; m_wrq = !ce_ni && !we_ni;
      if (!hw_rst_ni) begin m_st = IDLE; m_md = RD; m_mask = '0; end
      else if (m_st == PROG) begin
        if (m_cnt == 1) begin m_st = IDLE; if (m_md != BY) m_md = RD; end else m_cnt--;
      end else if (m_st == ERASE) begin
        if (stb && d == 'hB0) m_st = ESUSP;
        else if (m_cnt == 1) begin m_st = IDLE; m_md = RD; m_mask = '0; end
        else m_cnt--;
      end else if (m_st == EWIN) begin
        if (stb) begin
          if (d == 'h30) begin m_mask |= sbit; m_wcnt = WL; end
          else begin m_st = IDLE; m_mask = '0; if (f0) m_md = RD; end
        end else if (m_wcnt == 1) begin m_st = ERASE; m_cnt = EL; end
        else m_wcnt--;
      end else if (stb) begin
        case (m_st)
          IDLE: if (m_md == BY) begin
                  if (d == 'hA0) m_st = PADR; else if (d == 'h90) m_st = B90;
                end else if (f0) m_md = RD;
                else if (d == 'hAA && aa) m_st = U1;
          U1, EU1: if (d == 'h55 && bb) m_st = (m_st == U1) ? U2 : EU2;
                   else begin m_st = IDLE; if (f0) m_md = RD; end
          U2: begin
                m_st = IDLE;
                if (aa && d == 'hA0) m_st = PADR;
                else if (aa && d == 'h80) m_st = ESET;
                else if (aa && d == 'h90) m_md = ID;
                else if (aa && d == 'h20) m_md = BY;
                else if (f0) m_md = RD;
              end
          PADR: begin m_st = PROG; m_cnt = PL; end
          ESET: if (d == 'hAA && aa) m_st = EU1;
                else begin m_st = IDLE; if (f0) m_md = RD; end
          EU2: begin
                 m_st = IDLE;
                 if (aa && d == 'h10) begin m_st = ERASE; m_cnt = EL; m_mask = '1; end
                 else if (d == 'h30) begin m_st = EWIN; m_mask = sbit; m_wcnt = WL; end
                 else if (f0) m_md = RD;
               end
          ESUSP: if (d == 'h30) m_st = ERASE;
          B90: begin m_st = IDLE; if (d == 0) m_md = RD; end
          default: ;
        endcase
      end
    end
  end

  task automatic check();
    bit e_rdy, e_den, e_id;
    e_rdy = m_rdy();
    e_den = m_ok() && !ce_ni && !oe_ni;
    e_id  = (m_md == ID) && !(m_st == PROG || m_st == ERASE || m_st == ESUSP);
    vecs++;
    if (rdy_o !== e_rdy) begin fails++;
      $display("FAIL %s rdy_o act %0b exp %0b t=%0t", cur_req, rdy_o, e_rdy, $time); end
    if (dout_en_o !== e_den) begin fails++;
      $display("FAIL %s dout_en_o act %0b exp %0b t=%0t", cur_req, dout_en_o, e_den, $time); end
    if (id_sel_o !== e_id) begin fails++;
      $display("FAIL %s id_sel_o act %0b exp %0b t=%0t", cur_req, id_sel_o, e_id, $time); end
    if (erase_mask_o !== m_mask) begin fails++;
      $display("FAIL %s erase_mask_o act %h exp %h t=%0t", cur_req, erase_mask_o, m_mask, $time); end
  endtask

  task automatic drive(input bit ce, input bit we, input bit oe, input bit pin,
                       input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    ce_ni = ce; we_ni = we; oe_ni = oe; hw_rst_ni = pin; addr_i = a; data_i = d;
    #2 check();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    drive(0, 0, 1, hw_rst_ni, a, d);
    drive(0, 0, 1, hw_rst_ni, a, d); // second low cycle must not re-trigger (R1)
    drive(1, 1, 1, hw_rst_ni, a, d);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1, 1, 1, hw_rst_ni, addr_i, data_i);
  endtask
  task automatic rd(input int n);
    for (int i = 0; i < n; i++) drive(0, 1, 0, hw_rst_ni, addr_i, data_i);
  endtask
  task automatic desel(input int n);
    for (int i = 0; i < n; i++) drive(1, 1, 0, hw_rst_ni, addr_i, data_i);
  endtask
  task automatic pin(input bit v, input int n);
    for (int i = 0; i < n; i++) drive(1, 1, 1, v, addr_i, data_i);
  endtask
  task automatic unlock();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask
  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    cur_req = "R8"; // reset state
    idle(3);
    @(negedge clk_i); rst_ni = 1;
    idle(2); rd(2);
    // R4 identification mode and exit
    cur_req = "R4";
    unlock(); wr(12'h555, 8'h90); rd(3);
    wr(12'h000, 8'hF0); rd(2);
    // R1 normal program
    cur_req = "R1";
    unlock(); wr(12'h555, 8'hA0); wr(12'h123, 8'h5A); rd(PL + 3);
    // R3 mismatches, from read and from identification
    cur_req = "R3";
    wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h123, 8'h77); idle(3);
    unlock(); wr(12'h555, 8'h90); rd(1);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h54); rd(2);
    unlock(); wr(12'h554, 8'hA0); wr(12'h100, 8'h11); rd(3);
    unlock(); wr(12'h555, 8'hF0); rd(2);
    // R2 bypass
    cur_req = "R2";
    unlock(); wr(12'h555, 8'h20);
    wr(12'h044, 8'h33); idle(2);
    wr(12'h000, 8'hA0); wr(12'h321, 8'h12); idle(PL + 2);
    wr(12'h000, 8'hA0); wr(12'h322, 8'h13); idle(PL + 2);
    wr(12'h000, 8'h90); wr(12'h000, 8'h01); idle(2);
    wr(12'h000, 8'h90); wr(12'h000, 8'h00); idle(2);
    wr(12'h000, 8'hA0); wr(12'h323, 8'h14); idle(4);
    // R5 sector erase, two sectors, then aborted variant
    cur_req = "R5";
    unlock(); wr(12'h555, 8'h80); unlock();
    wr(12'h400, 8'h30); idle(2); wr(12'hC00, 8'h30); idle(WL + EL + 3);
    unlock(); wr(12'h555, 8'h80); unlock();
    wr(12'h800, 8'h30); wr(12'h000, 8'h55); idle(WL + 3);
    // R6 chip erase
    cur_req = "R6";
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h10); idle(EL + 3);
    // R7 writes ignored while busy, suspend and resume
    cur_req = "R7";
    unlock(); wr(12'h555, 8'hA0); wr(12'h010, 8'h01);
    wr(12'h555, 8'hF0); wr(12'h555, 8'hAA); idle(PL + 2);
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h10);
    idle(4); wr(12'h000, 8'hB0); rd(3); wr(12'h000, 8'hF0); wr(12'h555, 8'hAA); idle(3);
    wr(12'h000, 8'h30); idle(EL + 2);
    // R11 deselected reads and program completing while deselected
    cur_req = "R11";
    desel(3);
    unlock(); wr(12'h555, 8'hA0); wr(12'h020, 8'h02); desel(PL + 2); rd(2);
    // R9 reset while busy: long, writes during reset ignored (R8)
    cur_req = "R9";
    unlock(); wr(12'h555, 8'hA0); wr(12'h030, 8'h03); idle(1);
    pin(0, 2);
    cur_req = "R8";
    drive(0, 0, 0, 0, 12'h555, 8'hAA); drive(0, 1, 0, 0, 12'h555, 8'hAA);
    pin(1, RL + RC + 3);
    // R9 reset while idle: short, rdy stays high
    cur_req = "R9";
    pin(0, 1); pin(1, RS + RC + 3);
    // R10 release gap: write and reads right after release
    cur_req = "R10";
    unlock(); wr(12'h555, 8'h90); rd(1);
    pin(0, RL + 4);
    drive(0, 0, 0, 1, 12'h555, 8'hAA); drive(0, 1, 0, 1, 12'h2AA, 8'h55);
    rd(RC + 2);
    unlock(); wr(12'h555, 8'hA0); wr(12'h040, 8'h04); idle(3);
    pin(0, 2);
    cur_req = "R10";
    pin(1, 2); rd(RL + RC + 2); idle(PL);
    done = 1;
    summary();
    $finish;
  end
endmodule